// File: doc/BRIEF.md
# Buffered Configuration Word Mover

This peripheral sits between a processor's register bus and a configuration port that takes and gives 32-bit words. Software loads outbound words into a deep transmit queue, then writes a one-shot command that hands exactly the words present at that moment to the port under a valid/ready handshake. For readback, software programs a word count and issues a second command. The block then accepts that many words from the port into a shallow receive queue, pausing whenever the queue is full.

Software follows progress through a done flag, a free-slot count for the transmit queue and a fill count for the receive queue. Four event flags are set on the rising edge of queue conditions. Writing a 1 to an event flag toggles it. A per-source mask and a global gate combine the flags into one interrupt line. A flush command empties both queues, and a soft-reset command also returns every register to its default.

Top module: `cfg_port_ctrl`

## Requirements
- R1: Byte offsets: global gate 0x1C (bit 31), event flags 0x20 (bits 3:0), event mask 0x28 (bits 3:0), transmit data 0x100, receive data 0x104, readback length 0x108 (bits 11:0 kept), command 0x10C, status 0x110, free slots 0x114, fill count 0x118. The gate, mask and length read back what was written, and the command register reads 0.
- R2: The transmit queue holds 1024 words, and the free-slot register reads 1024 minus the words held. A bus write to a full queue is dropped, and the register stays 0.
- R3: The receive queue holds 256 words, and the fill register reads the words held. A bus read while it is empty returns 0 and leaves the count at 0.
- R4: Command bit 0 sends exactly the words held when it is taken, oldest first, on port_wdata while port_wvalid is high. Each word moves when port_wready is high. Words added afterwards stay queued.
- R5: Command bit 1 accepts length-register words from the port (port_rvalid and port_rready both high). port_rready is low while the receive queue is full. A length of 0 moves nothing.
- R6: Status bit 0 is 1 only when no send or readback is active and port_busy is low. Bits 4:1 read 1. Bit 5 is port_abort_n, bit 6 is readback active, bit 7 is port_align and bit 8 is port_cfg_err. All other bits read 0.
- R7: Command bits are single-cycle and are ignored while a transfer is active. If bits 0 and 1 are written together, only the send runs.
- R8: Command bit 2 empties both queues and cancels any active transfer. The gate, mask and length keep their values.
- R9: Command bit 3 empties both queues, cancels any transfer and clears the gate, mask, length and event flags.
- R10: An event flag is set on the rising edge of its condition: bit 3 receive full, bit 2 transmit empty, bit 1 receive fill at least 128, bit 0 transmit fill at least 512. A write of 1 toggles a flag. A rising edge in the same cycle as a toggle leaves the flag at 1.
- R11: irq is high when bit 31 of the gate register is 1 and at least one event flag is set whose mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe (pops the receive queue at 0x104) |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq | output | 1 | Interrupt line |
| port_wdata | output | 32 | Outbound word |
| port_wvalid | output | 1 | Outbound word valid |
| port_wready | input | 1 | Port accepts outbound word |
| port_rdata | input | 32 | Inbound word |
| port_rvalid | input | 1 | Inbound word valid |
| port_rready | output | 1 | Block accepts inbound word |
| port_busy | input | 1 | Port still processing |
| port_abort_n | input | 1 | Abort indication, active low |
| port_align | input | 1 | Alignment detected |
| port_cfg_err | input | 1 | Configuration error |

## Verification
Two things can land on the same event flag in one clock: a software toggle write, and the hardware rising edge of the condition behind that flag. The bench sets the transmit-empty flag by a toggle, then stalls a one-word send by holding port_wready low. It raises ready so that the last word leaves exactly one edge before the toggle write is taken, which puts the empty edge and the toggle in the same cycle. The flag must then read 1, where a toggle alone would give 0, and a separate toggle afterwards must clear it.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int OFS_GATE  = 'h01C;
    localparam int OFS_EVT   = 'h020;
    localparam int OFS_MASK  = 'h028;
    localparam int OFS_TXD   = 'h100;
    localparam int OFS_RXD   = 'h104;
    localparam int OFS_LEN   = 'h108;
    localparam int OFS_CMD   = 'h10C;
    localparam int OFS_STAT  = 'h110;
    localparam int OFS_FREE  = 'h114;
    localparam int OFS_FILL  = 'h118;

    localparam int CMD_SEND  = 0;
    localparam int CMD_FETCH = 1;
    localparam int CMD_FLUSH = 2;
    localparam int CMD_SRST  = 3;

    localparam int NUM_EVT   = 4;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_SEND  = 2'd1,
        XF_FETCH = 2'd2
    } xfer_mode_e;
endpackage

// File: rtl/cfgp_fifo.sv
module cfgp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic full, empty, do_push, do_pop;

    assign full    = (st_q.cnt == CNT_FULL);
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = (st_q.wp == PTR_LAST) ? '0 : st_q.wp + AW'(1);
            if (do_pop)  st_d.rp = (st_q.rp == PTR_LAST) ? '0 : st_q.rp + AW'(1);
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= din;
    end

    assign dout  = empty ? '0 : mem[st_q.rp];
    assign count = st_q.cnt;

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL);

    assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (st_q.cnt == $past(st_q.cnt)));

    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (st_q.cnt == '0));
endmodule

// File: rtl/cfgp_xfer.sv
module cfgp_xfer
    import cfgp_pkg::*;
#(
    parameter int WCW    = 11,
    parameter int LEN_W  = 12,
    localparam int RW    = (WCW > LEN_W) ? WCW : LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             go_send,
    input  logic             go_fetch,
    input  logic [WCW-1:0]   tx_count,
    input  logic [LEN_W-1:0] fetch_len,
    input  logic             port_wready,
    output logic             port_wvalid,
    output logic             tx_pop,
    input  logic             rx_full,
    input  logic             port_rvalid,
    output logic             port_rready,
    output logic             rx_push,
    output logic             sending,
    output logic             fetching
);
    typedef struct packed {
        xfer_mode_e    mode;
        logic [RW-1:0] left;
    } xfer_st_t;

    xfer_st_t st_d, st_q;
    logic hs_w, hs_r;

    assign hs_w = (st_q.mode == XF_SEND) && port_wready;
    assign hs_r = (st_q.mode == XF_FETCH) && !rx_full && port_rvalid;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.mode = XF_IDLE;
            st_d.left = '0;
        end else begin
            unique case (st_q.mode)
                XF_IDLE: begin
                    if (go_send) begin
                        if (tx_count != '0) begin
                            st_d.mode = XF_SEND;
                            st_d.left = RW'(tx_count);
                        end
                    end else if (go_fetch && fetch_len != '0) begin
                        st_d.mode = XF_FETCH;
                        st_d.left = RW'(fetch_len);
                    end
                end
                XF_SEND: begin
                    if (hs_w) begin
                        st_d.left = st_q.left - RW'(1);
                        if (st_q.left == RW'(1)) st_d.mode = XF_IDLE;
                    end
                end
                XF_FETCH: begin
                    if (hs_r) begin
                        st_d.left = st_q.left - RW'(1);
                        if (st_q.left == RW'(1)) st_d.mode = XF_IDLE;
                    end
                end
                default: st_d.mode = XF_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: XF_IDLE, left: '0};
        else        st_q <= st_d;
    end

    assign port_wvalid = (st_q.mode == XF_SEND);
    assign tx_pop      = hs_w;
    assign port_rready = (st_q.mode == XF_FETCH) && !rx_full;
    assign rx_push     = hs_r;
    assign sending     = (st_q.mode == XF_SEND);
    assign fetching    = (st_q.mode == XF_FETCH);

    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == XF_SEND && go_send && !port_wready && !clr)
        |=> (st_q.left == $past(st_q.left) && st_q.mode == XF_SEND));

    assert_send_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == XF_SEND && port_wready && st_q.left == RW'(1) && !clr)
        |=> (st_q.mode == XF_IDLE));

    assert_fetch_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == XF_FETCH && rx_full && !clr)
        |=> (st_q.left == $past(st_q.left)));
endmodule

// File: rtl/cfgp_evt.sv
module cfgp_evt #(
    parameter int          N        = 4,
    parameter logic [3:0]  COND_RST = 4'b0100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] cond,
    input  logic         tgl_en,
    input  logic [N-1:0] tgl,
    input  logic [N-1:0] en_mask,
    input  logic         gate,
    output logic [N-1:0] flags,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] flags;
        logic [N-1:0] prev;
    } evt_st_t;

    evt_st_t st_d, st_q;
    logic [N-1:0] rise;

    assign rise = cond & ~st_q.prev;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.flags = '0;
            st_d.prev  = COND_RST[N-1:0];
        end else begin
            st_d.prev  = cond;
            st_d.flags = (st_q.flags ^ (tgl_en ? tgl : '0)) | rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{flags: '0, prev: COND_RST[N-1:0]};
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign irq   = gate && |(st_q.flags & en_mask);

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_edge_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && cond[i] && !st_q.prev[i]) |=> st_q.flags[i]);
    end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfgp_pkg::*;
#(
    parameter int DW       = 32,
    parameter int ADDR_W   = 12,
    parameter int TX_DEPTH = 1024,
    parameter int RX_DEPTH = 256,
    parameter int LEN_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic [DW-1:0]     port_wdata,
    output logic              port_wvalid,
    input  logic              port_wready,
    input  logic [DW-1:0]     port_rdata,
    input  logic              port_rvalid,
    output logic              port_rready,
    input  logic              port_busy,
    input  logic              port_abort_n,
    input  logic              port_align,
    input  logic              port_cfg_err
);
    localparam int TCW = $clog2(TX_DEPTH + 1);
    localparam int RCW = $clog2(RX_DEPTH + 1);
    localparam logic [RCW-1:0] RX_FULL_CNT = RCW'(RX_DEPTH);
    localparam logic [RCW-1:0] RX_HALF_CNT = RCW'(RX_DEPTH / 2);
    localparam logic [TCW-1:0] TX_HALF_CNT = TCW'(TX_DEPTH / 2);

    typedef struct packed {
        logic                gate;
        logic [NUM_EVT-1:0]  mask;
        logic [LEN_W-1:0]    len;
    } regs_t;

    regs_t regs_d, regs_q;

    logic cmd_wr, srst, flush, go_send, go_fetch;
    logic tx_push, tx_pop, rx_push, rx_pop, rx_full;
    logic sending, fetching, done;
    logic [TCW-1:0] tx_count;
    logic [RCW-1:0] rx_count;
    logic [DW-1:0]  rx_dout, status;
    logic [NUM_EVT-1:0] cond, flags;

    function automatic logic hit(input logic en, input logic [ADDR_W-1:0] a, input int ofs);
        return en && (a == ADDR_W'(ofs));
    endfunction

    assign cmd_wr   = hit(bus_wr_en, bus_addr, OFS_CMD);
    assign srst     = cmd_wr && bus_wdata[CMD_SRST];
    assign flush    = cmd_wr && (bus_wdata[CMD_FLUSH] || bus_wdata[CMD_SRST]);
    assign go_send  = cmd_wr && !flush && bus_wdata[CMD_SEND];
    assign go_fetch = cmd_wr && !flush && bus_wdata[CMD_FETCH];
    assign tx_push  = hit(bus_wr_en, bus_addr, OFS_TXD);
    assign rx_pop   = hit(bus_rd_en, bus_addr, OFS_RXD);
    assign rx_full  = (rx_count == RX_FULL_CNT);

    always_comb begin
        regs_d = regs_q;
        if (srst) begin
            regs_d = '0;
        end else begin
            if (hit(bus_wr_en, bus_addr, OFS_GATE)) regs_d.gate = bus_wdata[DW-1];
            if (hit(bus_wr_en, bus_addr, OFS_MASK)) regs_d.mask = bus_wdata[NUM_EVT-1:0];
            if (hit(bus_wr_en, bus_addr, OFS_LEN))  regs_d.len  = bus_wdata[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    cfgp_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push(tx_push), .din(bus_wdata),
        .pop(tx_pop), .dout(port_wdata), .count(tx_count)
    );

    cfgp_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push(rx_push), .din(port_rdata),
        .pop(rx_pop), .dout(rx_dout), .count(rx_count)
    );

    cfgp_xfer #(.WCW(TCW), .LEN_W(LEN_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .go_send(go_send), .go_fetch(go_fetch),
        .tx_count(tx_count), .fetch_len(regs_q.len),
        .port_wready(port_wready), .port_wvalid(port_wvalid), .tx_pop(tx_pop),
        .rx_full(rx_full), .port_rvalid(port_rvalid), .port_rready(port_rready),
        .rx_push(rx_push), .sending(sending), .fetching(fetching)
    );

    assign cond = {rx_full, (tx_count == '0), (rx_count >= RX_HALF_CNT), (tx_count >= TX_HALF_CNT)};

    cfgp_evt #(.N(NUM_EVT), .COND_RST(4'b0100)) u_evt (
        .clk(clk), .rst_n(rst_n), .clr(srst), .cond(cond),
        .tgl_en(hit(bus_wr_en, bus_addr, OFS_EVT)), .tgl(bus_wdata[NUM_EVT-1:0]),
        .en_mask(regs_q.mask), .gate(regs_q.gate), .flags(flags), .irq(irq)
    );

    assign done = !sending && !fetching && !port_busy;

    always_comb begin
        status    = '0;
        status[0] = done;
        status[4:1] = 4'b1111;
        status[5] = port_abort_n;
        status[6] = fetching;
        status[7] = port_align;
        status[8] = port_cfg_err;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (int'(bus_addr))
            OFS_GATE: bus_rdata[DW-1] = regs_q.gate;
            OFS_EVT:  bus_rdata[NUM_EVT-1:0] = flags;
            OFS_MASK: bus_rdata[NUM_EVT-1:0] = regs_q.mask;
            OFS_RXD:  bus_rdata = rx_dout;
            OFS_LEN:  bus_rdata[LEN_W-1:0] = regs_q.len;
            OFS_STAT: bus_rdata = status;
            OFS_FREE: bus_rdata = DW'(TX_DEPTH) - DW'(tx_count);
            OFS_FILL: bus_rdata = DW'(rx_count);
            default:  bus_rdata = '0;
        endcase
    end

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_count == '0 && rx_count == '0 && !port_wvalid && !port_rready));

    assert_srst_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (regs_q == '0 && flags == '0));
endmodule

// File: tb/sim_cfg_port_ctrl.sv
module sim_cfg_port_ctrl;
    localparam logic [11:0] A_GATE = 12'h01C, A_EVT = 12'h020, A_MASK = 12'h028;
    localparam logic [11:0] A_TXD = 12'h100, A_RXD = 12'h104, A_LEN = 12'h108;
    localparam logic [11:0] A_CMD = 12'h10C, A_STAT = 12'h110, A_FREE = 12'h114, A_FILL = 12'h118;

    logic clk = 0, rst_n = 0;
    logic bus_wr_en = 0, bus_rd_en = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq, port_wvalid, port_rready;
    logic [31:0] port_wdata, port_rdata;
    logic port_wready = 0, port_rvalid = 0, port_busy = 0;
    logic port_abort_n = 1, port_align = 0, port_cfg_err = 0;

    int total = 0, bad = 0, tx_model = 0;
    logic [31:0] txq[$], rxq[$];
    logic [31:0] rb_gen = 32'hA500_0000;

    assign port_rdata = rb_gen;

    always #2 clk = ~clk;

    cfg_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .port_wdata(port_wdata), .port_wvalid(port_wvalid), .port_wready(port_wready),
        .port_rdata(port_rdata), .port_rvalid(port_rvalid), .port_rready(port_rready),
        .port_busy(port_busy), .port_abort_n(port_abort_n), .port_align(port_align),
        .port_cfg_err(port_cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1;
        @(negedge clk);
        bus_wr_en = 0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd_en = 0;
    endtask

    task automatic tx_put(input logic [31:0] d);
        if (tx_model < 1024) begin txq.push_back(d); tx_model++; end
        bus_wr(A_TXD, d);
    endtask

    task automatic rx_take(input string tag);
        logic [31:0] v;
        bus_rd(A_RXD, v);
        if (rxq.size() == 0) chk({tag, " unexpected word"}, v, 32'hFFFF_FFFF);
        else chk(tag, v, rxq.pop_front());
    endtask

    task automatic expect_reg(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] s;
        int n = 0;
        do begin bus_rd(A_STAT, s); n++; end while (!s[0] && n < 4000);
        chk(tag, 32'(s[0]), 32'd1);
    endtask

    // Scoreboard monitor: handshakes decided on stable inputs, taken at next edge
    initial begin
        forever begin
            logic hw, hr;
            @(negedge clk); #1;
            hw = port_wvalid && port_wready;
            hr = port_rvalid && port_rready;
            if (hw) begin
                if (txq.size() == 0) chk("R4 unexpected send", port_wdata, 32'hFFFF_FFFF);
                else begin chk("R4 send word", port_wdata, txq.pop_front()); tx_model--; end
            end
            if (hr) rxq.push_back(rb_gen);
            @(posedge clk); #1;
            if (hr) rb_gen = rb_gen + 32'd1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired got=hung exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // reset state
        expect_reg("R6 reset status", A_STAT, 32'h3F);
        expect_reg("R2 reset free", A_FREE, 32'd1024);
        expect_reg("R3 reset fill", A_FILL, 32'd0);
        expect_reg("R10 reset flags", A_EVT, 32'd0);
        chk("R11 reset irq", 32'(irq), 0);

        // R1 register access
        bus_wr(A_GATE, 32'h8000_0000);
        expect_reg("R1 gate", A_GATE, 32'h8000_0000);
        bus_wr(A_GATE, 32'h0);
        bus_wr(A_MASK, 32'hFF);
        expect_reg("R1 mask", A_MASK, 32'hF);
        bus_wr(A_MASK, 32'h0);
        bus_wr(A_LEN, 32'h1234);
        expect_reg("R1 length", A_LEN, 32'h234);
        expect_reg("R1 command reads 0", A_CMD, 32'h0);

        // R6 status inputs
        port_busy = 1; port_cfg_err = 1; port_align = 1; port_abort_n = 0;
        expect_reg("R6 status inputs", A_STAT, 32'h19E);
        port_busy = 0; port_cfg_err = 0; port_align = 0; port_abort_n = 1;

        // R4 send with later additions left queued
        port_wready = 1;
        for (int i = 0; i < 5; i++) tx_put(32'h1000 + i);
        bus_wr(A_CMD, 32'h1);
        tx_put(32'h2000); tx_put(32'h2001);
        wait_done("R4 send done");
        chk("R4 later words kept", txq.size(), 2);
        expect_reg("R4 free after send", A_FREE, 32'd1022);
        @(negedge clk) port_wready = 0;
        bus_wr(A_CMD, 32'h1);
        repeat (4) begin @(negedge clk) port_wready = ~port_wready; end
        port_wready = 1;
        wait_done("R4 second send done");
        chk("R4 all sent", txq.size(), 0);

        // R7 start ignored while busy, R6 done low while active
        @(negedge clk) port_wready = 0;
        for (int i = 0; i < 3; i++) tx_put(32'h3000 + i);
        bus_wr(A_CMD, 32'h1);
        tx_put(32'h3100);
        bus_wr(A_CMD, 32'h1);
        expect_reg("R6 status while sending", A_STAT, 32'h3E);
        @(negedge clk) port_wready = 1;
        wait_done("R7 send done");
        expect_reg("R7 restart ignored", A_FREE, 32'd1023);
        bus_wr(A_CMD, 32'h1);
        wait_done("R7 rest done");
        chk("R7 queue empty", txq.size(), 0);

        // R7 both bits: send only
        port_rvalid = 1;
        bus_wr(A_LEN, 32'd4);
        tx_put(32'h4000); tx_put(32'h4001);
        bus_wr(A_CMD, 32'h3);
        wait_done("R7 both bits done");
        expect_reg("R7 no fetch", A_FILL, 32'd0);
        chk("R7 sent", txq.size(), 0);

        // R5 readback, R3 empty read
        bus_wr(A_CMD, 32'h2);
        wait_done("R5 fetch done");
        expect_reg("R5 fill after fetch", A_FILL, 32'd4);
        for (int i = 0; i < 4; i++) rx_take("R5 fetched word");
        port_rvalid = 0;
        expect_reg("R3 empty read", A_RXD, 32'd0);
        expect_reg("R3 fill stays 0", A_FILL, 32'd0);
        bus_wr(A_LEN, 32'd0);
        port_rvalid = 1;
        bus_wr(A_CMD, 32'h2);
        repeat (3) @(posedge clk);
        expect_reg("R5 zero length", A_FILL, 32'd0);

        // R5 stall when full, R10 receive flags
        bus_wr(A_LEN, 32'd300);
        bus_wr(A_CMD, 32'h2);
        repeat (300) @(posedge clk);
        expect_reg("R5 stalled fill", A_FILL, 32'd256);
        bus_rd(A_STAT, v);
        chk("R6 fetch active bits", v & 32'h41, 32'h40);
        bus_rd(A_EVT, v);
        chk("R10 receive flags", v & 32'hA, 32'hA);
        for (int i = 0; i < 300; i++) rx_take("R5 stalled fetch word");
        wait_done("R5 long fetch done");
        expect_reg("R5 fill drained", A_FILL, 32'd0);
        port_rvalid = 0;

        // R10 toggle and same-cycle edge
        bus_rd(A_EVT, v);
        bus_wr(A_EVT, v);
        expect_reg("R10 toggle clears", A_EVT, 32'd0);
        @(negedge clk) port_wready = 0;
        tx_put(32'h5000);
        bus_wr(A_CMD, 32'h1);
        bus_wr(A_EVT, 32'h4);
        expect_reg("R10 toggle sets", A_EVT, 32'h4);
        @(negedge clk) port_wready = 1;
        bus_wr(A_EVT, 32'h4);
        expect_reg("R10 edge beats toggle", A_EVT, 32'h4);
        bus_wr(A_EVT, 32'h4);
        expect_reg("R10 toggle after race", A_EVT, 32'h0);

        // R11 interrupt gating
        bus_wr(A_EVT, 32'h4);
        bus_wr(A_MASK, 32'h4);
        bus_wr(A_GATE, 32'h8000_0000);
        #1 chk("R11 irq on", 32'(irq), 1);
        bus_wr(A_GATE, 32'h0);
        #1 chk("R11 gate off", 32'(irq), 0);
        bus_wr(A_GATE, 32'h8000_0000);
        bus_wr(A_MASK, 32'h8);
        #1 chk("R11 masked", 32'(irq), 0);

        // R8 flush
        port_rvalid = 1;
        bus_wr(A_LEN, 32'd4);
        bus_wr(A_CMD, 32'h2);
        wait_done("R8 prefetch done");
        port_rvalid = 0;
        @(negedge clk) port_wready = 0;
        for (int i = 0; i < 3; i++) tx_put(32'h6000 + i);
        bus_wr(A_CMD, 32'h1);
        bus_wr(A_CMD, 32'h4);
        txq.delete(); rxq.delete(); tx_model = 0;
        expect_reg("R8 free after flush", A_FREE, 32'd1024);
        expect_reg("R8 fill after flush", A_FILL, 32'd0);
        expect_reg("R8 transfer cancelled", A_STAT, 32'h3F);
        expect_reg("R8 gate kept", A_GATE, 32'h8000_0000);
        expect_reg("R8 length kept", A_LEN, 32'd4);

        // R9 soft reset
        bus_wr(A_MASK, 32'hF);
        bus_wr(A_EVT, 32'h3);
        tx_put(32'h7000);
        bus_wr(A_CMD, 32'h8);
        txq.delete(); tx_model = 0;
        expect_reg("R9 gate", A_GATE, 32'h0);
        expect_reg("R9 mask", A_MASK, 32'h0);
        expect_reg("R9 length", A_LEN, 32'h0);
        expect_reg("R9 flags", A_EVT, 32'h0);
        expect_reg("R9 free", A_FREE, 32'd1024);

        // R2 overfill and full drain
        for (int i = 0; i < 1030; i++) tx_put(32'h8000 + i);
        expect_reg("R2 free at full", A_FREE, 32'd0);
        bus_rd(A_EVT, v);
        chk("R10 transmit half flag", v & 32'h1, 32'h1);
        @(negedge clk) port_wready = 1;
        bus_wr(A_CMD, 32'h1);
        wait_done("R2 full send done");
        chk("R2 dropped words absent", txq.size(), 0);
        expect_reg("R2 free after drain", A_FREE, 32'd1024);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule